// File: doc/BRIEF.md
# Ripple-Carry ALU with Overflow-Safe Signed Compare

This block is a combinational arithmetic and logic unit of parameterised width. It is built as a chain of identical one-bit cells, with a separate cell for the top bit. Every cell can form the AND, the OR or the sum of its operand bits. Either operand may be inverted inside the cell, which gives subtraction (add the inverted second operand with a carry-in of one) and NOR. The carry ripples from bit 0 up to the top bit.

The top-bit cell also works out signed overflow and a "less than" decision. That decision is the sign of the difference corrected by the overflow, so the compare stays right when the subtraction wraps. The decision is routed back into the low cell's less input. All other less inputs are held at zero, so a compare returns 0...01 or 0...00. A 4-bit operation code selects the function. The flags report whether the result is zero, the carry out of the top bit and signed overflow.

Top module: `ripple_alu`

## Requirements
- R1: Code 4'b0000 (AND) gives result = a & b.
- R2: Code 4'b0001 (OR) gives result = a | b.
- R3: Code 4'b0010 (ADD) gives result = (a + b) mod 2^WIDTH, and carry is the unsigned carry out of the top bit.
- R4: Code 4'b0110 (SUB) gives result = (a - b) mod 2^WIDTH, and carry is 1 exactly when a >= b as unsigned numbers (no borrow).
- R5: For ADD, SUB and SLT, overflow is 1 exactly when the signed sum or difference lies outside the signed WIDTH-bit range. For AND, OR and NOR, carry and overflow are both 0.
- R6: Code 4'b0111 (SLT) gives result 1 when a < b as signed numbers, and 0 otherwise. All upper result bits are 0. This holds even when a - b overflows (at WIDTH=4, -7 vs 6 gives 1). Carry and overflow are those of a - b.
- R7: The zero flag is 1 exactly when every result bit is 0.
- R8: Code 4'b1100 (both operands inverted, AND selected) gives result = ~(a | b).
- R9: WIDTH is a parameter of at least 2, and this is checked at elaboration. The code layout is {invert a, invert b and carry-in, select[1:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code {invert a, invert b, select} |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Function result |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry out of the top bit for arithmetic codes, else 0 |
| ovf_o | output | 1 | Signed overflow for arithmetic codes, else 0 |

## Verification
There are no registers between the operands and any output. Result, zero, carry and overflow all belong to the same cycle in which the operands and code are applied. The bench drives a new code and operand pair just after each rising edge and reads all four outputs at the next falling edge. By then the whole carry chain, including the compare decision fed back into bit 0, has settled. The 4-bit copy is swept over every operand pair for every code. The 32-bit copy is driven with extreme values and random pairs.

// File: rtl/ripple_alu_pkg.sv
`timescale 1ns/1ps
package ripple_alu_pkg;

   typedef enum logic [1:0] {
      SEL_AND  = 2'b00,
      SEL_OR   = 2'b01,
      SEL_ADD  = 2'b10,
      SEL_LESS = 2'b11
   } slice_sel_e;

   typedef struct packed {
      logic       inv_a;
      logic       neg_b;
      slice_sel_e sel;
   } alu_ctrl_t;

   localparam logic [3:0] OPC_AND = 4'b0000;
   localparam logic [3:0] OPC_OR  = 4'b0001;
   localparam logic [3:0] OPC_ADD = 4'b0010;
   localparam logic [3:0] OPC_SUB = 4'b0110;
   localparam logic [3:0] OPC_SLT = 4'b0111;
   localparam logic [3:0] OPC_NOR = 4'b1100;

endpackage

// File: rtl/alu_full_adder.sv
`timescale 1ns/1ps
module alu_full_adder (
   input  logic x_i,
   input  logic y_i,
   input  logic c_i,
   output logic s_o,
   output logic c_o
);
   logic half;
   assign half = x_i ^ y_i;
   assign s_o  = half ^ c_i;
   assign c_o  = (x_i & y_i) | (c_i & half);
endmodule

// File: rtl/alu_bit_slice.sv
`timescale 1ns/1ps
module alu_bit_slice
   import ripple_alu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic       inv_a_i,
   input  logic       neg_b_i,
   input  logic       carry_i,
   input  logic       less_i,
   input  slice_sel_e sel_i,
   output logic       res_o,
   output logic       carry_o
);
   logic opa, opb, sum;

   assign opa = a_i ^ inv_a_i;
   assign opb = b_i ^ neg_b_i;

   alu_full_adder u_fa (
      .x_i (opa),
      .y_i (opb),
      .c_i (carry_i),
      .s_o (sum),
      .c_o (carry_o)
   );

   always_comb begin
      unique case (sel_i)
         SEL_AND:  res_o = opa & opb;
         SEL_OR:   res_o = opa | opb;
         SEL_ADD:  res_o = sum;
         default:  res_o = less_i;
      endcase
   end
endmodule

// File: rtl/alu_msb_slice.sv
`timescale 1ns/1ps
module alu_msb_slice
   import ripple_alu_pkg::*;
(
   input  logic       a_i,
   input  logic       b_i,
   input  logic       inv_a_i,
   input  logic       neg_b_i,
   input  logic       carry_i,
   input  logic       less_i,
   input  slice_sel_e sel_i,
   output logic       res_o,
   output logic       carry_o,
   output logic       set_o,
   output logic       ovf_o
);
   logic opa, opb, sum;

   assign opa = a_i ^ inv_a_i;
   assign opb = b_i ^ neg_b_i;

   alu_full_adder u_fa (
      .x_i (opa),
      .y_i (opb),
      .c_i (carry_i),
      .s_o (sum),
      .c_o (carry_o)
   );

   // signed overflow: carry entering the top bit disagrees with carry leaving it
   assign ovf_o = carry_i ^ carry_o;
   // true sign of the difference: raw sign flipped when the difference wrapped
   assign set_o = sum ^ ovf_o;

   always_comb begin
      unique case (sel_i)
         SEL_AND:  res_o = opa & opb;
         SEL_OR:   res_o = opa | opb;
         SEL_ADD:  res_o = sum;
         default:  res_o = less_i;
      endcase
   end
endmodule

// File: rtl/alu_zero_detect.sv
`timescale 1ns/1ps
module alu_zero_detect #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] value_i,
   output logic             zero_o
);
   assign zero_o = ~(|value_i);
endmodule

// File: rtl/ripple_alu.sv
`timescale 1ns/1ps
module ripple_alu
   import ripple_alu_pkg::*;
#(
   parameter  int WIDTH = 32,
   localparam int MSB   = WIDTH - 1
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o,
   output logic             carry_o,
   output logic             ovf_o
);
   if (WIDTH < 2) begin : g_width_bad
      $error("ripple_alu: WIDTH must be at least 2");
   end

   alu_ctrl_t ctrl;
   logic      slt_set, msb_carry, msb_ovf, arith;

   assign ctrl  = alu_ctrl_t'(op_i);
   assign arith = ctrl.sel[1];

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic cin, cout, res, less;

      if (i == 0) begin : g_lsb_in
         assign cin  = ctrl.neg_b;
         assign less = slt_set;
      end else begin : g_mid_in
         assign cin  = g_bit[i-1].cout;
         assign less = 1'b0;
      end

      if (i == MSB) begin : g_top
         alu_msb_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (ctrl.inv_a),
            .neg_b_i (ctrl.neg_b),
            .carry_i (cin),
            .less_i  (less),
            .sel_i   (ctrl.sel),
            .res_o   (res),
            .carry_o (cout),
            .set_o   (slt_set),
            .ovf_o   (msb_ovf)
         );
         assign msb_carry = cout;
      end else begin : g_plain
         alu_bit_slice u_slice (
            .a_i     (a_i[i]),
            .b_i     (b_i[i]),
            .inv_a_i (ctrl.inv_a),
            .neg_b_i (ctrl.neg_b),
            .carry_i (cin),
            .less_i  (less),
            .sel_i   (ctrl.sel),
            .res_o   (res),
            .carry_o (cout)
         );
      end

      assign result_o[i] = res;
   end

   alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
      .value_i (result_o),
      .zero_o  (zero_o)
   );

   assign carry_o = arith & msb_carry;
   assign ovf_o   = arith & msb_ovf;
endmodule

// File: rtl/ripple_alu_chk.sv
`timescale 1ns/1ps
module ripple_alu_chk
   import ripple_alu_pkg::*;
#(
   parameter  int WIDTH = 32,
   localparam int MSB   = WIDTH - 1
) (
   input  logic [3:0]       op_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] result_o,
   input  logic             zero_o,
   input  logic             carry_o,
   input  logic             ovf_o
);
   always_comb begin
      if (op_i == OPC_AND)
         p_and_r1: assert (result_o == (a_i & b_i)) else $error("R1 AND mismatch");
      if (op_i == OPC_OR)
         p_or_r2: assert (result_o == (a_i | b_i)) else $error("R2 OR mismatch");
      if (op_i == OPC_ADD)
         p_add_r3: assert ({carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("R3 ADD mismatch");
      if (op_i == OPC_SUB)
         p_sub_r4: assert ((result_o == a_i - b_i) && (carry_o == (a_i >= b_i)))
            else $error("R4 SUB mismatch");
      if (op_i == OPC_ADD)
         p_add_ovf_r5: assert (ovf_o == ((a_i[MSB] == b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
            else $error("R5 ADD overflow mismatch");
      if (op_i == OPC_SUB)
         p_sub_ovf_r5: assert (ovf_o == ((a_i[MSB] != b_i[MSB]) && (result_o[MSB] != a_i[MSB])))
            else $error("R5 SUB overflow mismatch");
      if (!op_i[1])
         p_logic_flags_r5: assert (!carry_o && !ovf_o) else $error("R5 logic flags set");
      if (op_i == OPC_SLT)
         p_slt_r6: assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
            else $error("R6 SLT mismatch");
      p_zero_r7: assert (zero_o == (result_o == '0)) else $error("R7 zero flag mismatch");
      if (op_i == OPC_NOR)
         p_nor_r8: assert (result_o == ~(a_i | b_i)) else $error("R8 NOR mismatch");
   end
endmodule

bind ripple_alu ripple_alu_chk #(.WIDTH(WIDTH)) u_chk (
   .op_i     (op_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .result_o (result_o),
   .zero_o   (zero_o),
   .carry_o  (carry_o),
   .ovf_o    (ovf_o)
);

// File: tb/ripple_alu_bench.sv
`timescale 1ns/1ps
module ripple_alu_bench;
   import ripple_alu_pkg::*;

   logic clk = 1'b0;
   always #10 clk = ~clk;  // 50 MHz

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [3:0]  op4  = '0, op32 = '0;
   logic [3:0]  a4   = '0, b4   = '0;
   logic [31:0] a32  = '0, b32  = '0;
   logic [3:0]  res4;
   logic [31:0] res32;
   logic        z4, c4, v4, z32, c32, v32;

   ripple_alu #(.WIDTH(32)) u_ripple_alu (
      .op_i (op32), .a_i (a32), .b_i (b32),
      .result_o (res32), .zero_o (z32), .carry_o (c32), .ovf_o (v32)
   );

   ripple_alu #(.WIDTH(4)) u_ripple_alu_n4 (
      .op_i (op4), .a_i (a4), .b_i (b4),
      .result_o (res4), .zero_o (z4), .carry_o (c4), .ovf_o (v4)
   );

   function automatic string req_of(input logic [3:0] op);
      case (op)
         OPC_AND: return "R1";
         OPC_OR:  return "R2";
         OPC_ADD: return "R3";
         OPC_SUB: return "R4";
         OPC_SLT: return "R6";
         default: return "R8";
      endcase
   endfunction

   // arithmetic model of the requirements
   function automatic void model(input int w, input logic [3:0] op,
                                 input logic [63:0] a, input logic [63:0] b,
                                 output logic [63:0] r, output logic c, output logic v);
      logic [63:0] mask, s;
      longint sa, sb, ss, maxv, minv;
      mask = (64'd1 << w) - 64'd1;
      maxv = longint'((64'd1 << (w - 1)) - 64'd1);
      minv = -maxv - 1;
      sa = longint'(a);
      sb = longint'(b);
      if (a[w-1]) sa = sa - longint'(64'd1 << w);
      if (b[w-1]) sb = sb - longint'(64'd1 << w);
      r = '0; c = 1'b0; v = 1'b0;
      case (op)
         OPC_AND: r = a & b;
         OPC_OR:  r = a | b;
         OPC_NOR: r = ~(a | b) & mask;
         OPC_ADD: begin
            s  = a + b;
            r  = s & mask;
            c  = s[w];
            ss = sa + sb;
            v  = (ss > maxv) || (ss < minv);
         end
         default: begin
            s  = a + (~b & mask) + 64'd1;
            c  = s[w];
            ss = sa - sb;
            v  = (ss > maxv) || (ss < minv);
            r  = (op == OPC_SUB) ? (s & mask) : ((sa < sb) ? 64'd1 : 64'd0);
         end
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
      end
   endtask

   task automatic compare(input logic [3:0] op, input int w,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic [63:0] got_r, input logic got_c,
                          input logic got_v, input logic got_z);
      logic [63:0] er;
      logic ec, ev;
      model(w, op, a, b, er, ec, ev);
      check(req_of(op), "result", got_r, er);
      check(req_of(op), "carry", {63'd0, got_c}, {63'd0, ec});
      check("R5", "overflow", {63'd0, got_v}, {63'd0, ev});
      check("R7", "zero", {63'd0, got_z}, {63'd0, (er == 64'd0)});
   endtask

   task automatic run4(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
      @(posedge clk);
      op4 = op; a4 = a; b4 = b;
      @(negedge clk);
      compare(op, 4, {60'd0, a}, {60'd0, b}, {60'd0, res4}, c4, v4, z4);
   endtask

   task automatic run32(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
      @(posedge clk);
      op32 = op; a32 = a; b32 = b;
      @(negedge clk);
      compare(op, 32, {32'd0, a}, {32'd0, b}, {32'd0, res32}, c32, v32, z32);
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         finish_run();
      end
   end

   initial begin
      logic [3:0]  ops [6];
      logic [31:0] edges [8];
      ops   = '{OPC_AND, OPC_OR, OPC_ADD, OPC_SUB, OPC_SLT, OPC_NOR};
      edges = '{32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                32'h8000_0000, 32'h8000_0001, 32'h7FFF_FFFE, 32'h0000_0002};

      // idle state: AND of zero operands gives zero result, flags clear (R7, R1)
      @(negedge clk);
      compare(OPC_AND, 32, 64'd0, 64'd0, {32'd0, res32}, c32, v32, z32);

      // R6: -7 vs 6 at width 4 wraps to 0011 yet must report less-than
      run4(OPC_SLT, 4'b1001, 4'b0110);
      check("R6", "slt -7<6", {60'd0, res4}, 64'd1);
      check("R5", "slt -7<6 overflow", {63'd0, v4}, 64'd1);

      // exhaustive width-4 sweep, all codes (R1 R2 R3 R4 R5 R6 R7 R8)
      for (int k = 0; k < 6; k++)
         for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
               run4(ops[k], 4'(x), 4'(y));

      // width-32 extremes (R9 second width, R5 overflow corners)
      for (int k = 0; k < 6; k++)
         for (int x = 0; x < 8; x++)
            for (int y = 0; y < 8; y++)
               run32(ops[k], edges[x], edges[y]);

      // width-32 random pairs
      for (int k = 0; k < 6; k++)
         for (int n = 0; n < 150; n++)
            run32(ops[k], $urandom, $urandom);

      done = 1'b1;
      finish_run();
   end
endmodule